// File: doc/BRIEF.md
# Vector Register Group Micro-op Sequencer

This block takes one vector instruction at a time. The instruction names three register groups (destination `vd`, sources `vs1` and `vs2`) and carries the current length-multiplier code, a widening mode and a masked flag. The block decodes the multiplier and works out the effective group size of each operand. It then checks that every group is aligned to its own size and that the configuration is not reserved.

If any check fails, the instruction is consumed and a one-cycle illegal pulse is raised. Otherwise the instruction is broken into single-register micro-ops, one per cycle on a valid/ready stream. Each micro-op carries physical register indices that step through the groups. The arithmetic, element masking and vector-length handling sit downstream.

The block sits between vector decode and the per-register execution pipes. It holds its input off until the last micro-op of the current instruction has been taken.

Top module: `vgrp_seq`

## Requirements
- R1: The multiplier code `vlmul_i` maps to a group size: 000→1, 001→2, 010→4 and 011→8. A legal non-widening instruction emits exactly that many micro-ops. The fractional codes 111, 110 and 101 (1/2, 1/4 and 1/8) emit exactly one micro-op.
- R2: The multiplier code 100 and the widening mode 11 are reserved. Either one raises illegal and emits no micro-op.
- R3: Each operand's register index must be a multiple of that operand's own effective group size (EMUL) whenever EMUL is greater than 1. Any misaligned operand raises illegal.
- R4: `wmode_i` selects the widening mode: 00 none, 01 wide destination only, 10 wide destination and wide `vs2`. A wide operand has EMUL = 2×LMUL and a narrow one keeps EMUL = LMUL. For an integer LMUL, a widening instruction emits 2×LMUL micro-ops.
- R5: An operand whose EMUL would exceed 8 raises illegal. A widening instruction with LMUL 8 is therefore always illegal.
- R6: A masked instruction (`masked_i`=1) whose destination group contains v0, that is `vd_i`=0, raises illegal. The mask register is v0.
- R7: On micro-op k (k = 0, 1, …), a full-rate operand index is base + k. In a widening instruction, a narrow source index is base + floor(k/2). The destination and a wide `vs2` are always full-rate.
- R8: `in_ready_o` is low from the cycle after a legal instruction is accepted until the cycle after its last micro-op is accepted. It is high whenever the block is idle.
- R9: While `uop_valid_o` is high and `uop_ready_i` is low, every micro-op output holds its value.
- R10: `illegal_o` is high for exactly the one cycle after an illegal instruction is accepted. The block stays ready afterwards.
- R11: While reset is asserted, and directly after it, `in_ready_o`=1, `uop_valid_o`=0 and `illegal_o`=0. A reset during emission drops the rest of the instruction.
- R12: `uop_last_o` is high only on the final micro-op of an instruction. `uop_masked_o` repeats the instruction's masked flag on every micro-op, and `uop_seq_o` gives k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Instruction accepted when high with valid |
| vd_i | input | 5 | Destination group base index |
| vs1_i | input | 5 | Source 1 group base index |
| vs2_i | input | 5 | Source 2 group base index |
| vlmul_i | input | 3 | Length multiplier code |
| wmode_i | input | 2 | Widening mode |
| masked_i | input | 1 | Instruction is masked by v0 |
| uop_valid_o | output | 1 | Micro-op valid |
| uop_ready_i | input | 1 | Micro-op accepted when high with valid |
| uop_vd_o | output | 5 | Physical destination register |
| uop_vs1_o | output | 5 | Physical source 1 register |
| uop_vs2_o | output | 5 | Physical source 2 register |
| uop_seq_o | output | 3 | Micro-op number within the instruction |
| uop_last_o | output | 1 | Final micro-op of the instruction |
| uop_masked_o | output | 1 | Masked flag of the instruction |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The bound checker watches several rules on every cycle. Input ready stays low while micro-ops are pending, and stalled micro-op outputs hold steady. The destination index steps by one between consecutive micro-ops, and a finished instruction stops emitting. The illegal pulse lasts one cycle and never coincides with a micro-op. A masked micro-op never targets v0. Other behaviours need the bench's concrete instructions: the decoded group size and micro-op count, the per-operand alignment against each operand's own EMUL, the half-rate stepping of narrow sources, and the rejection of reserved codes. These depend on input values that only a scenario with known expected indices can pin down.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;
  typedef enum logic [1:0] {
    WM_NONE   = 2'b00,
    WM_DST    = 2'b01,
    WM_DST_S2 = 2'b10,
    WM_RSVD   = 2'b11
  } wmode_e;

  // log2 of an effective group size, -3..4
  typedef logic signed [3:0] elg_t;

  localparam int unsigned NOPND  = 3;
  localparam int unsigned OP_VD  = 0;
  localparam int unsigned OP_VS1 = 1;
  localparam int unsigned OP_VS2 = 2;
endpackage

// File: rtl/vgrp_lmul_dec.sv
module vgrp_lmul_dec
  import vgrp_pkg::*;
(
  input  logic [2:0] vlmul_i,
  output elg_t       lg_o,
  output logic       rsvd_o
);
  always_comb begin
    rsvd_o = 1'b0;
    unique case (vlmul_i)
      3'b000: lg_o = 4'sd0;
      3'b001: lg_o = 4'sd1;
      3'b010: lg_o = 4'sd2;
      3'b011: lg_o = 4'sd3;
      3'b111: lg_o = -4'sd1;
      3'b110: lg_o = -4'sd2;
      3'b101: lg_o = -4'sd3;
      default: begin
        lg_o   = 4'sd0;
        rsvd_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vgrp_align_chk.sv
module vgrp_align_chk
  import vgrp_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  input  elg_t             elg_i,
  output logic             ok_o
);
  // fractional or unit groups impose no alignment
  always_comb begin
    ok_o = 1'b1;
    for (int b = 0; b < IDX_W; b++) begin
      if (idx_i[b] && (int'(elg_i) > b)) ok_o = 1'b0;
    end
  end
endmodule

// File: rtl/vgrp_uop_gen.sv
module vgrp_uop_gen
  import vgrp_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned CNT_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        accept_i,
  input  logic                        bad_i,
  input  logic [NOPND-1:0][IDX_W-1:0] base_i,
  input  logic [NOPND-1:0]            narrow_i,
  input  logic [CNT_W-1:0]            last_i,
  input  logic                        masked_i,
  input  logic                        uop_ready_i,
  output logic                        busy_o,
  output logic                        illegal_o,
  output logic [NOPND-1:0][IDX_W-1:0] uop_idx_o,
  output logic [CNT_W-1:0]            uop_seq_o,
  output logic                        uop_last_o,
  output logic                        uop_masked_o
);
  logic                        busy_q, ill_q, masked_q;
  logic [CNT_W-1:0]            k_q, last_q;
  logic [NOPND-1:0][IDX_W-1:0] base_q;
  logic [NOPND-1:0]            narrow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      ill_q    <= 1'b0;
      masked_q <= 1'b0;
      k_q      <= '0;
      last_q   <= '0;
      base_q   <= '0;
      narrow_q <= '0;
    end else begin
      ill_q <= accept_i && bad_i;
      if (accept_i && !bad_i) begin
        busy_q   <= 1'b1;
        k_q      <= '0;
        last_q   <= last_i;
        base_q   <= base_i;
        narrow_q <= narrow_i;
        masked_q <= masked_i;
      end else if (busy_q && uop_ready_i) begin
        if (k_q == last_q) busy_q <= 1'b0;
        else               k_q    <= k_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    logic [CNT_W-1:0] off;
    assign off          = narrow_q[i] ? (k_q >> 1) : k_q;
    assign uop_idx_o[i] = base_q[i] + IDX_W'(off);
  end

  assign busy_o       = busy_q;
  assign illegal_o    = ill_q;
  assign uop_seq_o    = k_q;
  assign uop_last_o   = busy_q && (k_q == last_q);
  assign uop_masked_o = masked_q;
endmodule

// File: rtl/vgrp_seq.sv
module vgrp_seq
  import vgrp_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned MAX_UOP = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic [IDX_W-1:0]             vd_i,
  input  logic [IDX_W-1:0]             vs1_i,
  input  logic [IDX_W-1:0]             vs2_i,
  input  logic [2:0]                   vlmul_i,
  input  logic [1:0]                   wmode_i,
  input  logic                         masked_i,
  output logic                         uop_valid_o,
  input  logic                         uop_ready_i,
  output logic [IDX_W-1:0]             uop_vd_o,
  output logic [IDX_W-1:0]             uop_vs1_o,
  output logic [IDX_W-1:0]             uop_vs2_o,
  output logic [$clog2(MAX_UOP)-1:0]   uop_seq_o,
  output logic                         uop_last_o,
  output logic                         uop_masked_o,
  output logic                         illegal_o
);
  localparam int unsigned CNT_W  = $clog2(MAX_UOP);
  localparam int          MAX_LG = $clog2(MAX_UOP);

  wmode_e wm;
  elg_t   lg, cnt_lg;
  logic   rsvd, wide_d, wide_s2, too_big, mask_hit, bad, busy, accept;
  logic [NOPND-1:0][IDX_W-1:0] base;
  elg_t [NOPND-1:0]            elg;
  logic [NOPND-1:0]            ok, narrow;
  logic [CNT_W-1:0]            last_k;

  assign wm = wmode_e'(wmode_i);

  vgrp_lmul_dec i_dec (
    .vlmul_i (vlmul_i),
    .lg_o    (lg),
    .rsvd_o  (rsvd)
  );

  assign wide_d  = (wm == WM_DST) || (wm == WM_DST_S2);
  assign wide_s2 = (wm == WM_DST_S2);

  assign base[OP_VD]  = vd_i;
  assign base[OP_VS1] = vs1_i;
  assign base[OP_VS2] = vs2_i;
  assign elg[OP_VD]   = wide_d  ? lg + 4'sd1 : lg;
  assign elg[OP_VS1]  = lg;
  assign elg[OP_VS2]  = wide_s2 ? lg + 4'sd1 : lg;

  // destination always has the largest group; it sets the micro-op count
  assign cnt_lg = (elg[OP_VD] > 4'sd0) ? elg[OP_VD] : 4'sd0;

  for (genvar i = 0; i < NOPND; i++) begin : g_chk
    vgrp_align_chk #(.IDX_W(IDX_W)) i_align (
      .idx_i (base[i]),
      .elg_i (elg[i]),
      .ok_o  (ok[i])
    );
    assign narrow[i] = elg[i] < cnt_lg;
  end

  always_comb begin
    last_k = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (int'(cnt_lg) > b) last_k[b] = 1'b1;
    end
  end

  assign too_big  = (int'(elg[OP_VD]) > MAX_LG) || (int'(elg[OP_VS2]) > MAX_LG);
  assign mask_hit = masked_i && (vd_i == '0);
  assign bad      = rsvd || (wm == WM_RSVD) || too_big || mask_hit || !(&ok);

  assign in_ready_o = !busy;
  assign accept     = in_valid_i && in_ready_o;

  logic [NOPND-1:0][IDX_W-1:0] uop_idx;

  vgrp_uop_gen #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .bad_i        (bad),
    .base_i       (base),
    .narrow_i     (narrow),
    .last_i       (last_k),
    .masked_i     (masked_i),
    .uop_ready_i  (uop_ready_i),
    .busy_o       (busy),
    .illegal_o    (illegal_o),
    .uop_idx_o    (uop_idx),
    .uop_seq_o    (uop_seq_o),
    .uop_last_o   (uop_last_o),
    .uop_masked_o (uop_masked_o)
  );

  assign uop_valid_o = busy;
  assign uop_vd_o    = uop_idx[OP_VD];
  assign uop_vs1_o   = uop_idx[OP_VS1];
  assign uop_vs2_o   = uop_idx[OP_VS2];
endmodule

// File: rtl/vgrp_seq_chk.sv
module vgrp_seq_chk #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned MAX_UOP = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       in_valid_i,
  input logic                       in_ready_o,
  input logic                       uop_valid_o,
  input logic                       uop_ready_i,
  input logic [IDX_W-1:0]           uop_vd_o,
  input logic [IDX_W-1:0]           uop_vs1_o,
  input logic [IDX_W-1:0]           uop_vs2_o,
  input logic [$clog2(MAX_UOP)-1:0] uop_seq_o,
  input logic                       uop_last_o,
  input logic                       uop_masked_o,
  input logic                       illegal_o
);
  p_no_ready_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o |-> !in_ready_o);

  p_hold_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_vd_o) &&
      $stable(uop_vs1_o) && $stable(uop_vs2_o) && $stable(uop_seq_o) &&
      $stable(uop_last_o) && $stable(uop_masked_o)));

  p_vd_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_ready_i && !uop_last_o) |=>
      (uop_valid_o && uop_vd_o == $past(uop_vd_o) + 1'b1));

  p_last_ends_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_ready_i && uop_last_o) |=> !uop_valid_o);

  p_ill_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);

  p_ill_no_uop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !uop_valid_o);

  p_mask_v0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_masked_o) |-> (uop_vd_o != '0));
endmodule

bind vgrp_seq vgrp_seq_chk #(.IDX_W(IDX_W), .MAX_UOP(MAX_UOP)) i_chk (.*);

// File: tb/test_vgrp_seq.sv
module test_vgrp_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       in_valid_i = 1'b0, masked_i = 1'b0, uop_ready_i = 1'b0;
  logic [4:0] vd_i = '0, vs1_i = '0, vs2_i = '0;
  logic [2:0] vlmul_i = '0;
  logic [1:0] wmode_i = '0;
  logic       in_ready_o, uop_valid_o, uop_last_o, uop_masked_o, illegal_o;
  logic [4:0] uop_vd_o, uop_vs1_o, uop_vs2_o;
  logic [2:0] uop_seq_o;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  vgrp_seq i_vgrp_seq (.*);

  typedef struct packed {
    logic [4:0] vd, vs1, vs2;
    logic [2:0] lm;
    logic [1:0] wm;
    logic       msk, ill;
    logic [3:0] cnt;
    logic       n1, n2, stall;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{5'd16, 5'd8,  5'd24, 3'b011, 2'b00, 1'b0, 1'b0, 4'd8, 1'b0, 1'b0, 1'b1}, // R1 R7 R9 lmul 8
    '{5'd4,  5'd0,  5'd12, 3'b010, 2'b00, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0}, // R1 lmul 4
    '{5'd5,  5'd2,  5'd4,  3'b001, 2'b00, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R3 v5 size 2
    '{5'd3,  5'd7,  5'd9,  3'b000, 2'b00, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0}, // R1 lmul 1
    '{5'd3,  5'd5,  5'd7,  3'b111, 2'b00, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0}, // R1 1/2
    '{5'd1,  5'd2,  5'd3,  3'b101, 2'b00, 1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0}, // R1 R12 1/8 masked
    '{5'd0,  5'd0,  5'd0,  3'b100, 2'b00, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R2 vlmul 100
    '{5'd4,  5'd2,  5'd6,  3'b001, 2'b01, 1'b0, 1'b0, 4'd4, 1'b1, 1'b1, 1'b1}, // R4 R7 wide dst
    '{5'd2,  5'd2,  5'd6,  3'b001, 2'b01, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R3 R4 vd not x4
    '{5'd8,  5'd4,  5'd16, 3'b010, 2'b10, 1'b0, 1'b0, 4'd8, 1'b1, 1'b0, 1'b0}, // R4 R7 wide vs2
    '{5'd8,  5'd4,  5'd12, 3'b010, 2'b10, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R3 v12 emul 8
    '{5'd0,  5'd8,  5'd16, 3'b011, 2'b01, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R5 widen lmul 8
    '{5'd0,  5'd2,  5'd4,  3'b001, 2'b00, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R6 masked vd v0
    '{5'd2,  5'd4,  5'd6,  3'b001, 2'b00, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0, 1'b1}, // R6 R12 masked ok
    '{5'd2,  5'd5,  5'd7,  3'b000, 2'b01, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 1'b0}, // R4 R7 lmul1 wide
    '{5'd3,  5'd3,  5'd3,  3'b110, 2'b01, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0}, // R4 frac wide
    '{5'd4,  5'd4,  5'd4,  3'b000, 2'b11, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}, // R2 wmode 11
    '{5'd24, 5'd9,  5'd24, 3'b011, 2'b00, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0}  // R3 vs1 v9
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic uop_chk(input vec_t v, input int k);
    chk("R1 uop valid", int'(uop_valid_o), 1);
    chk("R8 ready low", int'(in_ready_o), 0);
    chk("R7 vd", int'(uop_vd_o), int'(5'(v.vd + 5'(k))));
    chk("R7 vs1", int'(uop_vs1_o), int'(5'(v.vs1 + 5'(v.n1 ? k / 2 : k))));
    chk("R7 vs2", int'(uop_vs2_o), int'(5'(v.vs2 + 5'(v.n2 ? k / 2 : k))));
    chk("R12 seq", int'(uop_seq_o), k);
    chk("R12 last", int'(uop_last_o), int'(k == int'(v.cnt) - 1));
    chk("R12 masked", int'(uop_masked_o), int'(v.msk));
  endtask

  task automatic run(input vec_t v);
    @(negedge clk_i);
    chk("R8 ready idle", int'(in_ready_o), 1);
    in_valid_i = 1'b1; vd_i = v.vd; vs1_i = v.vs1; vs2_i = v.vs2;
    vlmul_i = v.lm; wmode_i = v.wm; masked_i = v.msk;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    if (v.ill) begin
      chk("R10 illegal pulse", int'(illegal_o), 1);
      chk("R2 no uop", int'(uop_valid_o), 0);
      @(negedge clk_i);
      chk("R10 pulse ends", int'(illegal_o), 0);
      chk("R2 no uop later", int'(uop_valid_o), 0);
      chk("R10 ready", int'(in_ready_o), 1);
    end else begin
      chk("R10 no illegal", int'(illegal_o), 0);
      for (int k = 0; k < int'(v.cnt); k++) begin
        uop_chk(v, k);
        if (v.stall && k == 1) begin
          @(negedge clk_i);
          uop_chk(v, k);  // R9 held under stall
        end
        uop_ready_i = 1'b1;
        @(negedge clk_i);
        uop_ready_i = 1'b0;
      end
      chk("R1 count done", int'(uop_valid_o), 0);
      chk("R8 ready after", int'(in_ready_o), 1);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    #5;
    chk("R11 reset ready", int'(in_ready_o), 1);
    chk("R11 reset valid", int'(uop_valid_o), 0);
    chk("R11 reset illegal", int'(illegal_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 after reset ready", int'(in_ready_o), 1);
    chk("R11 after reset valid", int'(uop_valid_o), 0);

    for (int i = 0; i < NV; i++) run(TBL[i]);

    // R11: reset part-way through an instruction
    @(negedge clk_i);
    in_valid_i = 1'b1; vd_i = 5'd8; vs1_i = 5'd16; vs2_i = 5'd24;
    vlmul_i = 3'b011; wmode_i = 2'b00; masked_i = 1'b0;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    uop_ready_i = 1'b1;
    @(negedge clk_i);
    uop_ready_i = 1'b0;
    chk("R11 mid vd", int'(uop_vd_o), 9);
    rst_ni = 1'b0;
    #2;
    chk("R11 mid drop", int'(uop_valid_o), 0);
    chk("R11 mid ready", int'(in_ready_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R11 stays idle", int'(uop_valid_o), 0);

    run(TBL[0]);  // clean instruction after reset

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule